// File: doc/BRIEF.md
# Data-Strobe Receive Decoder and Resynchroniser

This block takes a serial stream that arrives as a data/strobe line pair and recovers the bits without a separately delivered clock. The exclusive-OR of the two lines toggles once per bit, so the block uses it as a bit clock. Rising edges of that clock capture the even-numbered bits and falling edges capture the odd-numbered ones. The bits are gathered into 2, 4 or 8 bit words, depending on the receive speed code. Each finished word is written into a small gray-pointer FIFO. The FIFO moves the words into the local system-clock domain, where they are presented one at a time with a one-cycle valid flag.

On the receiving port the encoded data arrives on line pair A and the encoded strobe on line pair B, which is the reverse of the transmit assignment. While a packet is being received, the raw data and strobe levels are repeated onto every other connected port. The receiving port's own transmitter stays off. Packet boundaries come from an external receive-active input. When that input falls, any bits that have not yet filled a word are dropped.

Top module: `ds_rx_decoder`

## Requirements
- R1: Each change of `pair_a XOR pair_b` while `rx_active` is high marks exactly one received bit. The value of that bit is the level of `pair_a` just after the change. `pair_b` never supplies the bit value.
- R2: Every packet starts with both lines low. The first line change of a packet is bit 0 of the packet's first word.
- R3: `rx_speed` sets the word length. Code 0 gives 2 bits, code 1 gives 4 bits, and codes 2 and 3 give 8 bits. The code is held steady for the whole packet and until its last word has been delivered.
- R4: Words are left-aligned in `out_word`. The first bit of a word is placed in bit 7 and later bits follow in bit 6, bit 5 and so on. Bit positions below the word length read as 0.
- R5: Completed words appear on `out_word` in the order they were received. `out_valid` is high for exactly one `sys_clk` cycle per word.
- R6: When `rx_active` falls, any partially filled word is discarded. Once the words already completed have been delivered, `out_valid` stays low. The next packet starts word assembly afresh.
- R7: The domain crossing uses a FIFO with gray-coded pointers and two-flop synchronisers, `DEPTH` of at least 4. When words arrive more slowly than one per `sys_clk` period, the synchronised write pointer moves by at most one bit per cycle and the FIFO never holds more than `DEPTH` entries.
- R8: `rep_data[i]` carries `pair_a` and `rep_strobe[i]` carries `pair_b` for every port `i` whose `tx_en[i]` is high. Both outputs are low for every port whose `tx_en[i]` is low.
- R9: `tx_en[i]` is high exactly when `rx_active` is high, `port_connected[i]` is high, and `i` differs from `rx_port`. The receiving port's own transmitter is always off.
- R10: While `sys_rst` is high, and in the first cycle after it is released, `out_valid` and `out_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Local system clock |
| sys_rst | input | 1 | Active-high reset. It is synchronous in the local domain and clears the bit-clock side asynchronously. |
| pair_a | input | 1 | Line pair A level, which carries encoded data on receive |
| pair_b | input | 1 | Line pair B level, which carries encoded strobe on receive |
| rx_active | input | 1 | High for the duration of a received packet |
| rx_speed | input | 2 | Receive speed code that selects the word length |
| rx_port | input | PIDX_W | Index of the port that is receiving |
| port_connected | input | NUM_PORTS | One bit per port, high when the port is connected |
| out_word | output | 8 | Delivered word, left-aligned |
| out_valid | output | 1 | One-cycle strobe marking a delivered word |
| tx_en | output | NUM_PORTS | Per-port transmit enable for repeating |
| rep_data | output | NUM_PORTS | Repeated data line for each port |
| rep_strobe | output | NUM_PORTS | Repeated strobe line for each port |

## Verification
The assertions rely on three things about the inputs. The speed code does not change while words of a packet are still in flight. Both lines are low whenever `rx_active` rises. Words complete more slowly than one per `sys_clk` period, which is what lets the synchronised gray pointer move by at most one bit per cycle. The stimulus keeps to all three: each bit lasts 5 ns against an 8 ns system clock, so even 2-bit words come no faster than one per 10 ns. The line levels and speed code are set while `rx_active` is low, and the bench waits for the FIFO to drain before starting the next packet.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        SPD_W2  = 2'd0,
        SPD_W4  = 2'd1,
        SPD_W8  = 2'd2,
        SPD_W8B = 2'd3
    } rx_spd_e;

    // Bit pairs per word for each speed code.
    function automatic int unsigned pairs_per_word(input rx_spd_e s);
        case (s)
            SPD_W2:  return 1;
            SPD_W4:  return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] bin2gray(input logic [7:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [7:0] gray2bin(input logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

endpackage

// File: rtl/ds_bit_deser.sv
module ds_bit_deser
    import ds_rx_pkg::*;
(
    input  logic              bit_clk,
    input  logic              bit_clk_n,
    input  logic              clr,
    input  logic              a_line,
    input  rx_spd_e           speed,
    output logic              word_rdy,
    output logic [WORD_W-1:0] word
);
    localparam int PAIRS_MAX = WORD_W / 2;
    localparam int CW        = $clog2(PAIRS_MAX + 1);

    logic              ev_bit;
    logic [WORD_W-3:0] hist;
    logic [CW-1:0]     pair_cnt;
    logic [CW-1:0]     cnt_nxt;
    logic [WORD_W-1:0] joined;
    int unsigned       need;

    always_comb begin
        need     = pairs_per_word(speed);
        joined   = {hist, ev_bit, a_line};
        cnt_nxt  = pair_cnt + 1'b1;
        word_rdy = !clr && (cnt_nxt == CW'(need));
        word     = joined << (WORD_W - 2 * need);
    end

    // Even bits: rising transitions of the recovered clock.
    always_ff @(posedge bit_clk or posedge clr) begin
        if (clr) ev_bit <= 1'b0;
        else     ev_bit <= a_line;
    end

    // Odd bits close a pair on falling transitions.
    always_ff @(posedge bit_clk_n or posedge clr) begin
        if (clr) begin
            hist     <= '0;
            pair_cnt <= '0;
        end else begin
            hist     <= joined[WORD_W-3:0];
            pair_cnt <= word_rdy ? '0 : cnt_nxt;
        end
    end
endmodule

// File: rtl/ds_cdc_fifo.sv
module ds_cdc_fifo
    import ds_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [AW:0]       rd_gray_o,
    output logic [AW:0]       wq2_o
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rq1, rq2;
    logic [AW:0] rbin, rgray, wq1, wq2;
    logic        full;
    logic [AW:0] wbin_nx, rbin_nx;

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;
    assign full    = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});

    always_ff @(posedge wr_clk or posedge wr_rst) begin
        if (wr_rst) begin
            wbin  <= '0;
            wgray <= '0;
            rq1   <= '0;
            rq2   <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
            if (wr_en && !full) begin
                wbin  <= wbin_nx;
                wgray <= (AW+1)'(bin2gray(8'(wbin_nx)));
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rbin     <= '0;
            rgray    <= '0;
            wq1      <= '0;
            wq2      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            if (rgray != wq2) begin
                rd_data  <= mem[rbin[AW-1:0]];
                rd_valid <= 1'b1;
                rbin     <= rbin_nx;
                rgray    <= (AW+1)'(bin2gray(8'(rbin_nx)));
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end

    assign rd_gray_o = rgray;
    assign wq2_o     = wq2;
endmodule

// File: rtl/ds_rep_fanout.sv
module ds_rep_fanout #(
    parameter int NUM_PORTS = 6,
    parameter int PIDX_W    = $clog2(NUM_PORTS)
) (
    input  logic                 a_line,
    input  logic                 b_line,
    input  logic                 rx_active,
    input  logic [PIDX_W-1:0]    rx_port,
    input  logic [NUM_PORTS-1:0] connected,
    output logic [NUM_PORTS-1:0] tx_en,
    output logic [NUM_PORTS-1:0] rep_d,
    output logic [NUM_PORTS-1:0] rep_s
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign tx_en[i] = rx_active && connected[i] && (rx_port != PIDX_W'(i));
        assign rep_d[i] = tx_en[i] & a_line;
        assign rep_s[i] = tx_en[i] & b_line;
    end
endmodule

// File: rtl/ds_rx_decoder.sv
module ds_rx_decoder
    import ds_rx_pkg::*;
#(
    parameter int NUM_PORTS  = 6,
    parameter int PIDX_W     = $clog2(NUM_PORTS),
    parameter int FIFO_DEPTH = 8
) (
    input  logic                 sys_clk,
    input  logic                 sys_rst,
    input  logic                 pair_a,
    input  logic                 pair_b,
    input  logic                 rx_active,
    input  logic [1:0]           rx_speed,
    input  logic [PIDX_W-1:0]    rx_port,
    input  logic [NUM_PORTS-1:0] port_connected,
    output logic [7:0]           out_word,
    output logic                 out_valid,
    output logic [NUM_PORTS-1:0] tx_en,
    output logic [NUM_PORTS-1:0] rep_data,
    output logic [NUM_PORTS-1:0] rep_strobe
);
    localparam int AW = $clog2(FIFO_DEPTH);

    logic              bclk, bclk_n, bit_clr, word_rdy;
    logic [WORD_W-1:0] word;
    logic [AW:0]       fifo_rgray, fifo_wq2;

    assign bclk    = pair_a ^ pair_b;
    assign bclk_n  = ~bclk;
    assign bit_clr = sys_rst | ~rx_active;

    ds_bit_deser u_deser (
        .bit_clk   (bclk),
        .bit_clk_n (bclk_n),
        .clr       (bit_clr),
        .a_line    (pair_a),
        .speed     (rx_spd_e'(rx_speed)),
        .word_rdy  (word_rdy),
        .word      (word)
    );

    ds_cdc_fifo #(.DEPTH(FIFO_DEPTH), .AW(AW)) u_fifo (
        .wr_clk    (bclk_n),
        .wr_rst    (sys_rst),
        .wr_en     (word_rdy),
        .wr_data   (word),
        .rd_clk    (sys_clk),
        .rd_rst    (sys_rst),
        .rd_valid  (out_valid),
        .rd_data   (out_word),
        .rd_gray_o (fifo_rgray),
        .wq2_o     (fifo_wq2)
    );

    ds_rep_fanout #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_fan (
        .a_line    (pair_a),
        .b_line    (pair_b),
        .rx_active (rx_active),
        .rx_port   (rx_port),
        .connected (port_connected),
        .tx_en     (tx_en),
        .rep_d     (rep_data),
        .rep_s     (rep_strobe)
    );
endmodule

// File: rtl/ds_rx_checker.sv
module ds_rx_checker
    import ds_rx_pkg::*;
#(
    parameter int NUM_PORTS  = 6,
    parameter int PIDX_W     = 3,
    parameter int FIFO_DEPTH = 8,
    parameter int AW         = 3
) (
    input logic                 sys_clk,
    input logic                 sys_rst,
    input logic                 rx_active,
    input logic [1:0]           rx_speed,
    input logic [PIDX_W-1:0]    rx_port,
    input logic [NUM_PORTS-1:0] tx_en,
    input logic [7:0]           out_word,
    input logic                 out_valid,
    input logic [AW:0]          rgray,
    input logic [AW:0]          wq2
);
    logic [AW:0] occ;
    assign occ = (AW+1)'(gray2bin(8'(wq2)) - gray2bin(8'(rgray)));

    AST_OWN_TX_OFF: assert property (@(posedge sys_clk) disable iff (sys_rst)
        rx_active |-> !tx_en[rx_port]); // R9

    AST_NO_TX_IDLE: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !rx_active |-> (tx_en == '0)); // R9

    AST_GRAY_STEP: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $countones(wq2 ^ $past(wq2)) <= 1); // R7

    AST_NO_OVERFLOW: assert property (@(posedge sys_clk) disable iff (sys_rst)
        occ <= (AW+1)'(FIFO_DEPTH)); // R7

    AST_EMPTY_NO_VALID: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $past(rgray == wq2) |-> !out_valid); // R5

    AST_SHORT_WORD_PAD: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (out_valid && rx_speed == 2'd0) |-> (out_word[5:0] == 6'd0)); // R4

    AST_MID_WORD_PAD: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (out_valid && rx_speed == 2'd1) |-> (out_word[3:0] == 4'd0)); // R4
endmodule

bind ds_rx_decoder ds_rx_checker #(
    .NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W), .FIFO_DEPTH(FIFO_DEPTH), .AW(AW)
) u_chk (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .rx_active (rx_active),
    .rx_speed  (rx_speed),
    .rx_port   (rx_port),
    .tx_en     (tx_en),
    .out_word  (out_word),
    .out_valid (out_valid),
    .rgray     (fifo_rgray),
    .wq2       (fifo_wq2)
);

// File: tb/sim_ds_rx_decoder.sv
`timescale 1ns/1ps
module sim_ds_rx_decoder;
    localparam int NP = 6;
    localparam int PW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pa = 1'b0, pb = 1'b0, act = 1'b0;
    logic [1:0]    spd = 2'd0;
    logic [PW-1:0] port = '0;
    logic [NP-1:0] conn = '0;
    logic [7:0]    out_word;
    logic          out_valid;
    logic [NP-1:0] tx_en, rep_d, rep_s;

    int total = 0, bad = 0;
    logic [7:0] got[$];

    always #4 clk = ~clk;

    ds_rx_decoder #(.NUM_PORTS(NP), .PIDX_W(PW), .FIFO_DEPTH(8)) u0 (
        .sys_clk(clk), .sys_rst(rst), .pair_a(pa), .pair_b(pb),
        .rx_active(act), .rx_speed(spd), .rx_port(port), .port_connected(conn),
        .out_word(out_word), .out_valid(out_valid),
        .tx_en(tx_en), .rep_data(rep_d), .rep_strobe(rep_s)
    );

    always @(negedge clk) if (!rst && out_valid) got.push_back(out_word);

    task automatic chk(input string req, input logic ok, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    function automatic int word_len(input logic [1:0] s);
        return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [7:0] exp_word(input logic [63:0] pat, input int idx, input int wl);
        logic [7:0] w = '0;
        for (int j = 0; j < wl; j++) w[7-j] = pat[idx*wl + j];
        return w;
    endfunction

    task automatic send_pkt(input logic [1:0] s, input int nb, input logic [63:0] pat,
                            input logic [NP-1:0] c, input int p);
        logic [NP-1:0] exp_en;
        logic rep_ok = 1'b1;
        int wl = word_len(s);
        int nw = nb / wl;
        got.delete();
        spd = s; conn = c; port = PW'(p);
        pa = 1'b0; pb = 1'b0;
        #3 act = 1'b1;
        #5;
        exp_en = c & ~(NP'(1) << p);
        chk("R9 tx_en during receive", tx_en == exp_en, tx_en, exp_en);
        for (int i = 0; i < nb; i++) begin
            if (pat[i] != pa) pa = pat[i];
            else              pb = ~pb;
            #2;
            if (rep_d != (exp_en & {NP{pa}}) || rep_s != (exp_en & {NP{pb}})) rep_ok = 1'b0;
            #3;
        end
        chk("R8 repeat outputs follow lines", rep_ok, rep_d, exp_en & {NP{pa}});
        #5 act = 1'b0;
        #2 pa = 1'b0; pb = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R6 tx_en off when idle", tx_en == '0, tx_en, 0);
        chk("R6 valid low after drain", out_valid == 1'b0, out_valid, 0);
        chk("R3 R6 word count", got.size() == nw, got.size(), nw);
        for (int w = 0; w < nw && w < got.size(); w++)
            chk("R1 R4 R5 word value", got[w] == exp_word(pat, w, wl), got[w], exp_word(pat, w, wl));
    endtask

    initial begin
        void'($urandom(32'd1776));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 valid in reset", out_valid == 1'b0, out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 valid after reset", out_valid == 1'b0, out_valid, 0);
        chk("R10 word after reset", out_word == 8'h00, out_word, 0);
        chk("R9 tx_en at reset", tx_en == '0, tx_en, 0);
        // Directed: all ones exposes strobe-only toggling (R1, R2).
        send_pkt(2'd2, 16, 64'hFFFF, 6'b111111, 2);
        send_pkt(2'd0, 8, 64'h00, 6'b000011, 0);
        send_pkt(2'd3, 12, 64'hA5C, 6'b100001, 5);
        send_pkt(2'd1, 7, 64'h5B, 6'b010101, 1);
        send_pkt(2'd2, 1, 64'h1, 6'b000000, 3);
        for (int k = 0; k < 24; k++) begin
            logic [63:0] pat = {$urandom(), $urandom()};
            send_pkt(2'($urandom_range(0, 3)), $urandom_range(1, 48), pat,
                     NP'($urandom()), $urandom_range(0, NP-1));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule